// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block is the timing core of a one-wire bus master. It controls one open-drain data line from a fixed system clock. The line output is a drive-low enable only. The master never drives the line high, so an external pull-up restores it. The line input passes through a multi-flop synchroniser before the engine looks at it.

A client issues one command at a time with a valid strobe and a 3-bit opcode. The commands are:
- a bus reset with presence detection,
- a single write-0, write-1 or read slot,
- an eight-slot write or read of a data word, least significant bit first.

Each command raises `busy`. The result appears together with a one-cycle `done` strobe, in the same cycle that `busy` falls.

Every duration is a parameter in microseconds. A prescaler derives microseconds from `CLK_PER_US`. Each bit slot has a fixed total length, with the recovery gap already counted inside it. As a result, word operations take an exact and predictable number of cycles.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset, `busy`, `done` and `line_drive_low` are 0. Whenever `busy` is 0, the line is released.
- R2: Opcode 0 (bus reset) drives the line low for exactly T_RST_LOW_US (480 us). `done` is seen T_RST_SLOT_US (960 us) after the command is accepted.
- R3: For a bus reset, `result_bit` is 1 when the synchronised line is low at T_PRES_SAMP_US (70 us) after the line is released, and 0 when it is high there.
- R4: Opcode 1 (write 0) drives low for T_W0_LOW_US (60 us). Opcode 2 (write 1) drives low for T_W1_LOW_US (6 us). Each bit slot lasts T_SLOT_US + T_REC_US (72 us) from acceptance to `done`.
- R5: Opcode 3 (read bit) drives low for T_RD_LOW_US (2 us). `result_bit` is the line level sampled at T_RD_SAMP_US (12 us) after the slot starts.
- R6: Between consecutive low pulses, the line stays released for at least T_REC_US (2 us).
- R7: Opcode 4 (write word) sends the DATA_W bits of `cmd_data`, bit 0 first, as back-to-back write slots. It takes DATA_W × 72 us.
- R8: Opcode 5 (read word) runs DATA_W read slots. The first sampled bit lands in bit 0 of `result_data`.
- R9: `done` is high for exactly one cycle, in the cycle where `busy` is already 0. The results are valid in that cycle.
- R10: A `cmd_valid` that arrives while `busy` is high is ignored. The running operation keeps its pulses and its length.
- R11: Opcodes 6 and 7 are ignored: `busy` stays 0 and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | Opcode: 0 reset, 1 write 0, 2 write 1, 3 read bit, 4 write word, 5 read word |
| cmd_data | input | DATA_W | Word to write for opcode 4 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result_bit | output | 1 | Presence flag (reset) or sampled bit (read bit) |
| result_data | output | DATA_W | Word collected by opcode 5 |
| line_in | input | 1 | Level seen on the one-wire line |
| line_drive_low | output | 1 | Pull-down enable for the open-drain line |

## Verification
The hardest situation to reach from the ports is a command that arrives in the middle of a word operation. It must leave both the pulse train and the total length untouched. To reach it, the bench injects a reset opcode partway through a write word, then measures every low pulse and the completion cycle.

The presence and read windows can only be exercised with a responding slave. A reactive slave model in the bench watches the master's pulses and answers them:
- after a long low it sends a presence pulse, or stays silent when presence is turned off,
- in read slots it holds the line low for a randomly chosen 0 bit.

Write data is decoded back from the measured pulse widths.

// File: rtl/owm_pkg.sv
package owm_pkg;

   typedef enum logic [1:0] {
      SLOT_RST = 2'd0,
      SLOT_W0  = 2'd1,
      SLOT_W1  = 2'd2,
      SLOT_RD  = 2'd3
   } slot_kind_e;

   typedef enum logic [2:0] {
      OP_RESET  = 3'd0,
      OP_WR0    = 3'd1,
      OP_WR1    = 3'd2,
      OP_RDBIT  = 3'd3,
      OP_WRWORD = 3'd4,
      OP_RDWORD = 3'd5
   } op_e;

   localparam logic [2:0] OP_LAST_VALID = 3'd5;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= IDLE_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= IDLE_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
   parameter int CLK_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);

   localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + PW'(1);
      end
   end

   assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer
   import owm_pkg::*;
#(
   parameter int CLK_PER_US      = 100,
   parameter int T_RST_LOW_US    = 480,
   parameter int T_RST_SLOT_US   = 960,
   parameter int T_PRES_SAMP_US  = 70,
   parameter int T_SLOT_US       = 70,
   parameter int T_REC_US        = 2,
   parameter int T_W0_LOW_US     = 60,
   parameter int T_W1_LOW_US     = 6,
   parameter int T_RD_LOW_US     = 2,
   parameter int T_RD_SAMP_US    = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  slot_kind_e kind_i,
   input  logic       line_i,
   output logic       drive_low_o,
   output logic       finish_o,
   output logic       sample_o
);

   localparam int UW        = $clog2(T_RST_SLOT_US + 1);
   localparam int BIT_TOTAL = T_SLOT_US + T_REC_US;
   localparam int RST_SAMP  = T_RST_LOW_US + T_PRES_SAMP_US;

   logic          active_q;
   slot_kind_e    kind_q;
   logic [UW-1:0] us_q;
   logic          samp_q;
   logic          tick;
   logic [UW-1:0] low_lim, total_lim, samp_lim;

   owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_i),
      .en_i   (active_q),
      .tick_o (tick)
   );

   always_comb begin
      total_lim = UW'(BIT_TOTAL);
      samp_lim  = UW'(T_RD_SAMP_US);
      unique case (kind_q)
         SLOT_RST: begin
            low_lim   = UW'(T_RST_LOW_US);
            total_lim = UW'(T_RST_SLOT_US);
            samp_lim  = UW'(RST_SAMP);
         end
         SLOT_W0: low_lim = UW'(T_W0_LOW_US);
         SLOT_W1: low_lim = UW'(T_W1_LOW_US);
         default: low_lim = UW'(T_RD_LOW_US);
      endcase
   end

   assign finish_o    = active_q && tick && (us_q == total_lim - UW'(1));
   assign drive_low_o = active_q && (us_q < low_lim);
   assign sample_o    = samp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         kind_q   <= SLOT_RD;
         us_q     <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         kind_q   <= kind_i;
         us_q     <= '0;
      end else if (finish_o) begin
         active_q <= 1'b0;
      end else if (tick) begin
         us_q <= us_q + UW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         samp_q <= 1'b1;
      else if (active_q && tick && (us_q == samp_lim - UW'(1)))
         samp_q <= line_i;
   end

endmodule

// File: rtl/owm_shift.sv
module owm_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              shift_i,
   input  logic              in_bit_i,
   output logic              cur_bit_o,
   output logic              next_bit_o,
   output logic [DATA_W-1:0] shifted_o
);

   logic [DATA_W-1:0] sh_q;

   assign shifted_o  = {in_bit_i, sh_q[DATA_W-1:1]};
   assign cur_bit_o  = sh_q[0];
   assign next_bit_o = sh_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_i)  sh_q <= load_val_i;
      else if (shift_i) sh_q <= shifted_o;
   end

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
   import owm_pkg::*;
#(
   parameter int CLK_PER_US      = 100,
   parameter int DATA_W          = 8,
   parameter int SYNC_STAGES     = 2,
   parameter int T_RST_LOW_US    = 480,
   parameter int T_RST_SLOT_US   = 960,
   parameter int T_PRES_SAMP_US  = 70,
   parameter int T_SLOT_US       = 70,
   parameter int T_REC_US        = 2,
   parameter int T_W0_LOW_US     = 60,
   parameter int T_W1_LOW_US     = 6,
   parameter int T_RD_LOW_US     = 2,
   parameter int T_RD_SAMP_US    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              busy,
   output logic              done,
   output logic              result_bit,
   output logic [DATA_W-1:0] result_data,
   input  logic              line_in,
   output logic              line_drive_low
);

   localparam int BW = $clog2(DATA_W);
   localparam logic [BW-1:0] IDX_LAST = BW'(DATA_W - 1);

   // elaboration-time parameter checks
   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (T_RST_LOW_US < 480) begin : g_bad_rst
         $error("reset low time below 480 us");
      end
      if (T_RST_LOW_US + T_PRES_SAMP_US >= T_RST_SLOT_US) begin : g_bad_pres
         $error("presence sample point must fall inside the reset slot");
      end
      if (T_W0_LOW_US < 60 || T_W0_LOW_US >= T_SLOT_US) begin : g_bad_w0
         $error("write-0 low time out of range");
      end
      if (T_W1_LOW_US < 1 || T_W1_LOW_US >= 15) begin : g_bad_w1
         $error("write-1 low time out of range");
      end
      if (T_RD_LOW_US < 1 || T_RD_SAMP_US <= T_RD_LOW_US || T_RD_SAMP_US >= 15) begin : g_bad_rd
         $error("read timing out of range");
      end
      if (T_REC_US < 1) begin : g_bad_rec
         $error("recovery time below 1 us");
      end
   endgenerate

   logic              line_sync;
   logic              busy_q, word_q, rdword_q, rstop_q, done_q, res_bit_q;
   logic [BW-1:0]     idx_q;
   logic [DATA_W-1:0] res_data_q;
   logic              accept, op_ok, last_slot, more, slot_start, slot_finish, slot_sample;
   logic              cur_bit, next_bit;
   logic [DATA_W-1:0] shifted;
   slot_kind_e        first_kind, kind_sel;

   owm_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_in),
      .q_o   (line_sync)
   );

   assign op_ok     = (cmd_op <= OP_LAST_VALID);
   assign accept    = cmd_valid && !busy_q && op_ok;
   assign last_slot = !word_q || (idx_q == IDX_LAST);
   assign more      = slot_finish && !last_slot;
   assign slot_start = accept || more;

   always_comb begin
      unique case (cmd_op)
         OP_RESET:  first_kind = SLOT_RST;
         OP_WR0:    first_kind = SLOT_W0;
         OP_WR1:    first_kind = SLOT_W1;
         OP_WRWORD: first_kind = cmd_data[0] ? SLOT_W1 : SLOT_W0;
         default:   first_kind = SLOT_RD;
      endcase
   end

   always_comb begin
      if (accept)        kind_sel = first_kind;
      else if (rdword_q) kind_sel = SLOT_RD;
      else               kind_sel = next_bit ? SLOT_W1 : SLOT_W0;
   end

   owm_slot_timer #(
      .CLK_PER_US     (CLK_PER_US),
      .T_RST_LOW_US   (T_RST_LOW_US),
      .T_RST_SLOT_US  (T_RST_SLOT_US),
      .T_PRES_SAMP_US (T_PRES_SAMP_US),
      .T_SLOT_US      (T_SLOT_US),
      .T_REC_US       (T_REC_US),
      .T_W0_LOW_US    (T_W0_LOW_US),
      .T_W1_LOW_US    (T_W1_LOW_US),
      .T_RD_LOW_US    (T_RD_LOW_US),
      .T_RD_SAMP_US   (T_RD_SAMP_US)
   ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (slot_start),
      .kind_i      (kind_sel),
      .line_i      (line_sync),
      .drive_low_o (line_drive_low),
      .finish_o    (slot_finish),
      .sample_o    (slot_sample)
   );

   owm_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (cmd_data),
      .shift_i    (slot_finish && word_q),
      .in_bit_i   (slot_sample),
      .cur_bit_o  (cur_bit),
      .next_bit_o (next_bit),
      .shifted_o  (shifted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         word_q     <= 1'b0;
         rdword_q   <= 1'b0;
         rstop_q    <= 1'b0;
         idx_q      <= '0;
         done_q     <= 1'b0;
         res_bit_q  <= 1'b0;
         res_data_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q   <= 1'b1;
            word_q   <= (cmd_op == OP_WRWORD) || (cmd_op == OP_RDWORD);
            rdword_q <= (cmd_op == OP_RDWORD);
            rstop_q  <= (cmd_op == OP_RESET);
            idx_q    <= '0;
         end else if (more) begin
            idx_q <= idx_q + BW'(1);
         end else if (slot_finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (!word_q)
               res_bit_q <= rstop_q ? ~slot_sample : slot_sample;
            if (word_q && rdword_q)
               res_data_q <= shifted;
         end
      end
   end

   assign busy        = busy_q;
   assign done        = done_q;
   assign result_bit  = res_bit_q;
   assign result_data = res_data_q;

   // cur_bit is consumed through first_kind via cmd_data; keep it observable
   logic unused_cur;
   assign unused_cur = cur_bit;

endmodule

// File: rtl/owm_slot_engine_chk.sv
module owm_slot_engine_chk #(
   parameter int CLK_PER_US   = 100,
   parameter int T_RST_LOW_US = 480,
   parameter int T_REC_US     = 2,
   parameter int T_W0_LOW_US  = 60,
   parameter int T_W1_LOW_US  = 6,
   parameter int T_RD_LOW_US  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic line_drive_low
);

   localparam int unsigned SAT = 32'd1000000;

   int unsigned low_cnt;
   int unsigned rel_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= 0;
         rel_cnt <= SAT;
      end else if (line_drive_low) begin
         low_cnt <= low_cnt + 1;
         rel_cnt <= 0;
      end else begin
         low_cnt <= 0;
         if (rel_cnt < SAT) rel_cnt <= rel_cnt + 1;
      end
   end

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_drive_low);

   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_drive_low) |->
         (low_cnt == T_RST_LOW_US * CLK_PER_US) || (low_cnt == T_W0_LOW_US * CLK_PER_US) ||
         (low_cnt == T_W1_LOW_US * CLK_PER_US) || (low_cnt == T_RD_LOW_US * CLK_PER_US));

   assert_recovery_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_drive_low) |-> (rel_cnt >= T_REC_US * CLK_PER_US));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_start_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

endmodule

bind owm_slot_engine owm_slot_engine_chk #(
   .CLK_PER_US   (CLK_PER_US),
   .T_RST_LOW_US (T_RST_LOW_US),
   .T_REC_US     (T_REC_US),
   .T_W0_LOW_US  (T_W0_LOW_US),
   .T_W1_LOW_US  (T_W1_LOW_US),
   .T_RD_LOW_US  (T_RD_LOW_US)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .busy           (busy),
   .done           (done),
   .line_drive_low (line_drive_low)
);

// File: tb/owm_slot_engine_bench.sv
module owm_slot_engine_bench;

   localparam int CPU      = 2;
   localparam int RST_LOW  = 480;
   localparam int RST_TOT  = 960;
   localparam int W0_LOW   = 60;
   localparam int W1_LOW   = 6;
   localparam int RD_LOW   = 2;
   localparam int BIT_TOT  = 72;
   localparam int REC      = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_data = 8'd0;
   logic       busy, done, result_bit, line_drive_low;
   logic [7:0] result_data;
   logic       line_in;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench slave model state
   logic        slave_low = 1'b0;
   logic        drv_d = 1'b0;
   int unsigned lo_cnt = 0, hi_cnt = 0, min_gap = 32'hFFFF_FFFF;
   int unsigned plen [0:63];
   int          np = 0;
   int unsigned slave_cnt = 0, pres_wait = 0;
   bit          pres_en = 1'b1;
   bit          rd_en = 1'b0;
   logic [7:0]  rd_bits = 8'hFF;
   int          rd_idx = 0;

   always #5 clk = ~clk;

   assign line_in = ~(line_drive_low | slave_low);

   owm_slot_engine #(.CLK_PER_US(CPU)) u_owm_slot_engine (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_valid      (cmd_valid),
      .cmd_op         (cmd_op),
      .cmd_data       (cmd_data),
      .busy           (busy),
      .done           (done),
      .result_bit     (result_bit),
      .result_data    (result_data),
      .line_in        (line_in),
      .line_drive_low (line_drive_low)
   );

   // reactive slave, evaluated away from the active edge
   always @(negedge clk) begin
      if (slave_cnt != 0) begin
         slave_cnt = slave_cnt - 1;
         if (slave_cnt == 0) slave_low = 1'b0;
      end
      if (pres_wait != 0) begin
         pres_wait = pres_wait - 1;
         if (pres_wait == 0) begin
            slave_low = 1'b1;
            slave_cnt = 120 * CPU;
         end
      end
      if (line_drive_low && !drv_d) begin
         if (np > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
         if (rd_en) begin
            if (!rd_bits[rd_idx[2:0]]) begin
               slave_low = 1'b1;
               slave_cnt = 30 * CPU;
            end
            rd_idx = rd_idx + 1;
         end
      end
      if (!line_drive_low && drv_d) begin
         if (np < 64) plen[np] = lo_cnt;
         np = np + 1;
         if (lo_cnt >= 240 * CPU && pres_en) pres_wait = 30 * CPU;
      end
      if (line_drive_low) begin lo_cnt = lo_cnt + 1; hi_cnt = 0; end
      else begin lo_cnt = 0; hi_cnt = hi_cnt + 1; end
      drv_d = line_drive_low;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int word_cycles();
      return 8 * BIT_TOT * CPU + 1;
   endfunction

   function automatic logic [7:0] decode_written();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = (plen[i] < 15 * CPU);
      return v;
   endfunction

   task automatic clear_log();
      np = 0;
      min_gap = 32'hFFFF_FFFF;
   endtask

   // issue a command at a negedge; optionally inject a reset opcode mid-run
   task automatic run_op(input logic [2:0] op, input logic [7:0] data,
                         input bit intrude, output int cyc);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 20000) begin
         if (intrude && cyc == 300) begin cmd_valid = 1'b1; cmd_op = 3'd0; end
         if (intrude && cyc == 302) cmd_valid = 1'b0;
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int cyc;
      int unsigned seed;
      logic [7:0] v;
      seed = $urandom(32'd20240611);

      repeat (4) @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 drive", line_drive_low, 0);

      // bus reset with and without a responding slave (R2, R3)
      pres_en = 1'b1; clear_log();
      run_op(3'd0, 8'h00, 1'b0, cyc);
      chk("R2 reset length", cyc, RST_TOT * CPU + 1);
      chk("R2 reset low width", plen[0], RST_LOW * CPU);
      chk("R3 presence seen", result_bit, 1);
      chk("R9 busy low with done", busy, 0);
      @(negedge clk);
      chk("R9 done single cycle", done, 0);

      repeat (300) @(negedge clk);
      pres_en = 1'b0; clear_log();
      run_op(3'd0, 8'h00, 1'b0, cyc);
      chk("R3 no presence", result_bit, 0);
      repeat (5) @(negedge clk);

      // single write slots (R4)
      clear_log();
      run_op(3'd1, 8'h00, 1'b0, cyc);
      chk("R4 write0 length", cyc, BIT_TOT * CPU + 1);
      chk("R4 write0 width", plen[0], W0_LOW * CPU);
      clear_log();
      run_op(3'd2, 8'h00, 1'b0, cyc);
      chk("R4 write1 length", cyc, BIT_TOT * CPU + 1);
      chk("R4 write1 width", plen[0], W1_LOW * CPU);

      // single read slots (R5)
      for (int b = 0; b < 2; b++) begin
         clear_log(); rd_en = 1'b1; rd_idx = 0; rd_bits = {7'h7F, b[0]};
         run_op(3'd3, 8'h00, 1'b0, cyc);
         rd_en = 1'b0;
         chk("R5 read bit value", result_bit, b);
         chk("R5 read low width", plen[0], RD_LOW * CPU);
         chk("R5 read length", cyc, BIT_TOT * CPU + 1);
         repeat (40 * CPU) @(negedge clk);
      end

      // word writes: fixed corners plus random words (R7, R6)
      for (int t = 0; t < 5; t++) begin
         v = (t == 0) ? 8'h00 : (t == 1) ? 8'hFF : 8'($urandom);
         clear_log();
         run_op(3'd4, v, 1'b0, cyc);
         chk("R7 word write length", cyc, word_cycles());
         chk("R7 word write slot count", np, 8);
         chk("R7 word write data LSB first", decode_written(), v);
         if (t == 0) chk("R6 recovery gap met", (min_gap >= REC * CPU), 1);
      end

      // word reads (R8)
      for (int t = 0; t < 4; t++) begin
         v = (t == 0) ? 8'h01 : 8'($urandom);
         clear_log(); rd_en = 1'b1; rd_idx = 0; rd_bits = v;
         run_op(3'd5, 8'h00, 1'b0, cyc);
         rd_en = 1'b0;
         chk("R8 word read data", result_data, v);
         chk("R8 word read length", cyc, word_cycles());
         repeat (40 * CPU) @(negedge clk);
      end

      // command while busy is ignored (R10)
      v = 8'hA5; pres_en = 1'b1; clear_log();
      run_op(3'd4, v, 1'b1, cyc);
      chk("R10 length unchanged", cyc, word_cycles());
      chk("R10 slot count unchanged", np, 8);
      chk("R10 data unchanged", decode_written(), v);
      repeat (4) @(negedge clk);
      chk("R10 no late start", busy, 0);

      // undefined opcodes ignored (R11)
      for (int op = 6; op < 8; op++) begin
         clear_log();
         cmd_valid = 1'b1; cmd_op = 3'(op);
         @(negedge clk);
         cmd_valid = 1'b0;
         repeat (20) @(negedge clk);
         chk("R11 busy stays low", busy, 0);
         chk("R11 no pulses", np + int'(line_drive_low), 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule